// File: doc/BRIEF.md
# Coincident-Current Core Memory Sequencer

This block runs every access to a 64-byte ferrite core store built from eight bit-planes of 8x8 cores. Plane p holds bit p of every byte. A 6-bit address picks one core in each plane through one of eight active-low row selects and one of eight active-low column selects, which feed external H-bridges. A core switches only when its row line and its column line are both driven. A single polarity bit sets the drive direction for both lines. Each plane has one wire that carries both sensing and inhibit. A switching core produces a negative-going pulse on that wire. The block captures these pulses during the read, and during the restore it drives inhibit on the same wire to hold selected cores at 0.

Reads destroy the stored byte, so every access runs two drive pulses. The first pulse drives toward 0 and captures which planes flipped. The second pulse drives toward 1, with inhibit asserted on the planes that must stay 0. A read writes back the captured byte. A write stores the new byte in the same way and returns the byte it replaced. Pulse widths and the quiet gaps that follow each pulse are clock-count parameters. The external drivers, sense amplifiers and cores are outside the block.

Top module: `core_mem_ctrl`

## Requirements
- R1: After reset, busy and ack are low, all row and column selects are high (inactive), inhibit is all zero and the drive polarity bit is low.
- R2: The row index is addr[5:3] and the column index is addr[2:0]. Driving row r means row_sel_n bit r is 0; driving column c means col_sel_n bit c is 0. At most one row select and at most one column select are low at any time, and the row select is low exactly when the column select is low.
- R3: The read pulse holds the selected row and column low for exactly PULSE_CYC cycles with drive_one low. rdata bit p is 1 exactly when sense_n[p] went low during that pulse.
- R4: drive_one does not change while the selects are low. After each pulse, all selects stay high for GAP_CYC cycles.
- R5: The restore pulse holds the same selects low for PULSE_CYC cycles with drive_one high. inhibit bit p is 1 exactly when bit p of the byte being restored is 0. After a read, the stored byte is unchanged.
- R6: inhibit is nonzero only while a restore pulse is being driven. A low level on sense_n outside the read pulse has no effect on rdata.
- R7: A write (we=1) runs the same two pulses and stores wdata, with the restore using wdata in place of the captured byte. rdata returns the byte held before the write.
- R8: busy rises on the edge that accepts req and stays high until the access completes. ack is high for exactly one cycle, the last busy cycle. ack is first seen 2*PULSE_CYC+2*GAP_CYC+1 edges after the edge that sampled req.
- R9: req, addr, we and wdata have no effect while busy. A request held through an access does not start a second access if it is released in the ack cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address (row in [5:3], column in [2:0]) |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte captured by the last access |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion strobe |
| row_sel_n | output | 8 | Active-low row line selects |
| col_sel_n | output | 8 | Active-low column line selects |
| drive_one | output | 1 | Drive polarity: 1 toward one, 0 toward zero |
| inhibit | output | 8 | Per-plane inhibit drive, active high |
| sense_n | input | 8 | Per-plane sense pulses, active low |

## Verification
On every cycle, the assertions check that the select pattern is legal (one row with one column, always together), the exact width of each drive pulse, that the polarity holds steady within a pulse, that inhibit appears only in a toward-one pulse, and how ack relates to busy. The bench drives a core-array model that flips a core only on a full coincident select. Only this model can show whether the captured bytes, the restore after a destructive read, the old value returned on a write, the rejection of restore-phase sense pulses and the exact access latency are right. Stimulus is random addresses and data from a fixed seed, plus directed edge addresses and all-ones and all-zeros bytes.

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl #(
  parameter int PULSE_CYC = 320,
  parameter int GAP_CYC   = 8,
  parameter int SIDE      = 8,
  parameter int PLANES    = 8,
  localparam int IW = $clog2(SIDE),
  localparam int AW = 2 * IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [PLANES-1:0] wdata,
  output logic [PLANES-1:0] rdata,
  output logic              busy,
  output logic              ack,
  output logic [SIDE-1:0]   row_sel_n,
  output logic [SIDE-1:0]   col_sel_n,
  output logic              drive_one,
  output logic [PLANES-1:0] inhibit,
  input  logic [PLANES-1:0] sense_n
);
  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_READ, S_GAP1, S_REST, S_GAP2, S_DONE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [PLANES-1:0] wd_q;
  logic [PLANES-1:0] cap;
  logic              pulse, last;
  logic [PLANES-1:0] rest_data;

  assign pulse     = (st == S_READ) || (st == S_REST);
  assign last      = pulse ? (cnt == CW'(PULSE_CYC - 1)) : (cnt == CW'(GAP_CYC - 1));
  assign rest_data = we_q ? wd_q : cap;

  assign busy      = (st != S_IDLE);
  assign ack       = (st == S_DONE);
  assign drive_one = (st == S_REST);
  assign row_sel_n = pulse ? ~(SIDE'(1) << addr_q[AW-1:IW]) : '1;
  assign col_sel_n = pulse ? ~(SIDE'(1) << addr_q[IW-1:0])  : '1;
  assign inhibit   = (st == S_REST) ? ~rest_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      cap    <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          addr_q <= addr;
          we_q   <= we;
          wd_q   <= wdata;
          st     <= S_CLR;
        end
        S_CLR: begin
          cap <= '0;
          cnt <= '0;
          st  <= S_READ;
        end
        S_DONE: st <= S_IDLE;
        default: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (st == S_READ) cap <= cap | ~sense_n;
          if (last) begin
            case (st)
              S_READ:  st <= S_GAP1;
              S_GAP1:  st <= S_REST;
              S_REST:  st <= S_GAP2;
              default: begin
                st    <= S_DONE;
                rdata <= cap;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/core_mem_ctrl_chk.sv
module core_mem_ctrl_chk #(
  parameter int PULSE_CYC = 320,
  parameter int SIDE      = 8,
  parameter int PLANES    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ack,
  input logic [SIDE-1:0]   row_sel_n,
  input logic [SIDE-1:0]   col_sel_n,
  input logic              drive_one,
  input logic [PLANES-1:0] inhibit
);
  logic active, active_q;
  int   run;
  assign active = (row_sel_n != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 0;
      active_q <= 1'b0;
    end else begin
      run <= active ? run + 1 : 0;
      active_q <= active;
    end
  end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~row_sel_n)); // R2
  AST_ONE_COL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~col_sel_n)); // R2
  AST_ROW_WITH_COL: assert property (@(posedge clk) disable iff (!rst_n) (row_sel_n != '1) == (col_sel_n != '1)); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (active_q && !active) |-> (run == PULSE_CYC)); // R3
  AST_POLARITY_HELD: assert property (@(posedge clk) disable iff (!rst_n) (active && active_q) |-> $stable(drive_one)); // R4
  AST_INHIBIT_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) (inhibit != '0) |-> (active && drive_one)); // R6
  AST_ACK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ack |-> busy); // R8
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ack |=> (!busy && !ack)); // R8
endmodule

bind core_mem_ctrl core_mem_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .SIDE(SIDE), .PLANES(PLANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ack(ack), .row_sel_n(row_sel_n),
  .col_sel_n(col_sel_n), .drive_one(drive_one), .inhibit(inhibit)
);

// File: tb/sim_core_mem_ctrl.sv
`timescale 1ns/1ps
module sim_core_mem_ctrl;
  localparam int P = 24;
  localparam int G = 4;
  localparam int LAT = 2 * P + 2 * G + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, inhibit, sense_n;
  logic busy, ack, drive_one;
  logic [7:0] row_sel_n, col_sel_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] core [64];
  logic [7:0] shadow [64];
  int sp [8];

  always #2 clk = ~clk;

  core_mem_ctrl #(.PULSE_CYC(P), .GAP_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .ack(ack), .row_sel_n(row_sel_n),
    .col_sel_n(col_sel_n), .drive_one(drive_one), .inhibit(inhibit), .sense_n(sense_n)
  );

  function automatic int low_idx(input logic [7:0] v);
    int k = -1;
    int c = 0;
    for (int i = 0; i < 8; i++) if (!v[i]) begin k = i; c++; end
    return (c == 1) ? k : -1;
  endfunction

  always_comb for (int p = 0; p < 8; p++) sense_n[p] = (sp[p] == 0);

  initial begin
    for (int i = 0; i < 64; i++) begin core[i] = 8'(i * 37 + 5); shadow[i] = 8'(i * 37 + 5); end
    for (int p = 0; p < 8; p++) sp[p] = 0;
  end

  always @(posedge clk) begin
    int r, c, a;
    r = low_idx(row_sel_n);
    c = low_idx(col_sel_n);
    a = r * 8 + c;
    for (int p = 0; p < 8; p++) begin
      if (rst_n && r >= 0 && c >= 0 && !drive_one && core[a][p]) begin
        core[a][p] <= 1'b0; sp[p] <= 2;
      end else if (rst_n && r >= 0 && c >= 0 && drive_one && !inhibit[p] && !core[a][p]) begin
        core[a][p] <= 1'b1; sp[p] <= 2;
      end else if (sp[p] != 0) sp[p] <= sp[p] - 1;
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic access(input bit w, input logic [5:0] a, input logic [7:0] d, input bit hold);
    int n;
    logic [7:0] old, rest;
    old = shadow[a];
    rest = w ? d : old;
    we = w; addr = a; wdata = d; req = 1'b1;
    @(posedge clk); #1;
    n = 1;
    if (!hold) req = 1'b0;
    addr = 6'($urandom); wdata = 8'($urandom); we = ~w;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    while (!ack && n < 1000) begin
      @(posedge clk); #1; n++;
      if (n == 4) begin
        check(row_sel_n == ~(8'd1 << a[5:3]) && col_sel_n == ~(8'd1 << a[2:0]), "R2 decode",
              {row_sel_n, col_sel_n}, {~(8'd1 << a[5:3]), ~(8'd1 << a[2:0])});
        check(drive_one == 1'b0 && inhibit == 8'h00, "R3 read polarity", {drive_one, inhibit}, 0);
      end
      if (n == 3 + P) check(row_sel_n == 8'hFF && col_sel_n == 8'hFF, "R4 gap idle", row_sel_n, 8'hFF);
      if (n == 4 + P + G) check(drive_one == 1'b1 && inhibit == ~rest, "R5 restore inhibit",
                                {drive_one, inhibit}, {1'b1, ~rest});
    end
    if (hold) req = 1'b0;
    check(n == LAT, "R8 latency", n, LAT);
    check(rdata == old, w ? "R7 old value on write" : "R3 read data", rdata, old);
    if (w) shadow[a] = d;
    @(posedge clk); #1;
    check(busy == 1'b0 && ack == 1'b0, "R9 no extra access", {busy, ack}, 0);
  endtask

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && ack == 0 && row_sel_n == 8'hFF && col_sel_n == 8'hFF && inhibit == 0 && drive_one == 0,
          "R1 reset", {busy, ack, row_sel_n, col_sel_n, inhibit}, {2'b00, 16'hFFFF, 8'h00});
    rst_n = 1'b1;
    @(posedge clk); #1;
    access(1'b1, 6'd0, 8'hFF, 1'b0);
    access(1'b1, 6'd63, 8'h00, 1'b0);
    access(1'b0, 6'd0, 8'h00, 1'b0);
    access(1'b0, 6'd0, 8'h00, 1'b0);   // R5 read twice: value restored
    access(1'b0, 6'd63, 8'h00, 1'b0);
    access(1'b1, 6'd7, 8'hA5, 1'b1);   // R9 request held through access
    access(1'b1, 6'd56, 8'h5A, 1'b0);
    access(1'b0, 6'd7, 8'h00, 1'b0);   // R6 restore-phase sense pulses ignored
    access(1'b0, 6'd56, 8'h00, 1'b0);
    for (int i = 0; i < 120; i++) begin
      bit w = 1'($urandom);
      access(w, 6'($urandom), 8'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 64; i++) access(1'b0, 6'(i), 8'h00, 1'b0);  // R2 R7 full readback
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule